// File: doc/BRIEF.md
# IQ Phase Imbalance Corrector

This block is a streaming stage placed in front of a pair of DACs that feed an analog quadrature modulator. Each clock it may accept one signed 10-bit sample pair (I, Q). It moves the phase between the two channels away from exact quadrature by a small signed angle that software programs. The aim is to cancel the phase error of the modulator, which would otherwise show up as an unwanted sideband.

The angle is a signed 10-bit two's-complement code, from -512 to +511. Two 8-bit configuration bytes supply it, one holding the low part and one the high part. One code step equals 1/2048 radian. Over the whole code range the I/Q phase therefore spans about 75.7 to 104.3 degrees.

The block uses a small-angle cross term. I passes through unchanged. Q receives the product of the code and I, scaled by 1/2048, rounded and then clamped. Results come out two cycles after the input, together with a valid flag.

Top module: `iq_phase_trim`

## Requirements
- R1: While `rst` is high at a rising edge, and after that edge, `out_valid`, `out_i` and `out_q` are all zero.
- R2: A pair accepted at a rising edge with `in_valid` high appears two rising edges later with `out_valid` high. `out_valid` is low in every cycle that has no such accepted pair.
- R3: `out_i` equals the `in_i` of the same accepted pair, bit for bit.
- R4: The code is `{cfg_hi[1:0], cfg_lo[7:0]}`, read as signed two's complement with bit 9 as the sign. Bits 7:2 of `cfg_hi` have no effect.
- R5: With a code of zero, `out_q` equals the accepted `in_q`, so the block is transparent.
- R6: Before the clamp, `out_q = in_q + floor((code*in_i + 1024) / 2048)`. This is round to nearest, with exact halves rounded toward plus infinity. For example, code 4 with I 256 adds 1, and code -4 with I 256 adds 0.
- R7: `out_q` is clamped to the range -512 to +511 and never wraps.
- R8: The code is sampled at the same edge as its sample pair. A change to the code bytes after that edge leaves the pair's result unchanged.
- R9: While no new pair arrives, `out_i` and `out_q` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair is valid |
| in_i | input | 10 | Signed I sample |
| in_q | input | 10 | Signed Q sample |
| cfg_lo | input | 8 | Low byte of the correction code |
| cfg_hi | input | 8 | High byte of the correction code (bits 1:0 used) |
| out_valid | output | 1 | Output pair is valid |
| out_i | output | 10 | Delayed I sample |
| out_q | output | 10 | Corrected, clamped Q sample |

## Verification
A corrupted product register or a broken rounding constant shows up as a wrong `out_q` on the very output cycle that carries the affected pair, two edges after it was accepted. A slip in the valid or I pipeline shows up at once as misalignment: `out_valid` or `out_i` lands a cycle early or late, or `out_i` pairs with the wrong `out_q`. Back-to-back pairs with a code that changes every cycle expose any code that is captured late, because a neighbour's angle then leaks into the result. Extreme operands show any wrap in the adder, which would flip the sign of `out_q` instead of pinning it at a rail.

// File: rtl/iqpt_pkg.sv
package iqpt_pkg;
    // Default datapath geometry
    localparam int SAMPLE_W   = 10;
    localparam int CODE_W     = 10;
    localparam int REG_W      = 8;
    localparam int FRAC_SHIFT = 11;
    localparam int LATENCY    = 2;

    // Integer clamp used by width-independent checks and helpers
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction
endpackage

// File: rtl/iqpt_code_join.sv
module iqpt_code_join #(
    parameter int REG_W  = iqpt_pkg::REG_W,
    parameter int CODE_W = iqpt_pkg::CODE_W
) (
    input  logic [REG_W-1:0]         lo_byte,
    input  logic [REG_W-1:0]         hi_byte,
    output logic signed [CODE_W-1:0] code
);
    localparam int HI_BITS = CODE_W - REG_W;

    generate
        if (HI_BITS > 0) begin : g_two_bytes
            // Only the low HI_BITS of the high byte are used; the rest are ignored (R4)
            assign code = {hi_byte[HI_BITS-1:0], lo_byte};
        end else begin : g_one_byte
            logic unused_hi;
            assign unused_hi = ^hi_byte;
            assign code = lo_byte[CODE_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/iqpt_mul_stage.sv
module iqpt_mul_stage #(
    parameter int SAMPLE_W = iqpt_pkg::SAMPLE_W,
    parameter int CODE_W   = iqpt_pkg::CODE_W,
    localparam int PROD_W  = SAMPLE_W + CODE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    input  logic signed [CODE_W-1:0]   code,
    output logic                       s1_valid,
    output logic signed [SAMPLE_W-1:0] s1_i,
    output logic signed [SAMPLE_W-1:0] s1_q,
    output logic signed [PROD_W-1:0]   s1_prod
);
    logic signed [PROD_W-1:0] prod_c;

    // Full-precision signed product; the code is captured with its sample (R8)
    assign prod_c = PROD_W'(in_i) * PROD_W'(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_i    <= in_i;
                s1_q    <= in_q;
                s1_prod <= prod_c;
            end
        end
    end
endmodule

// File: rtl/iqpt_sum_stage.sv
module iqpt_sum_stage #(
    parameter int SAMPLE_W   = iqpt_pkg::SAMPLE_W,
    parameter int CODE_W     = iqpt_pkg::CODE_W,
    parameter int FRAC_SHIFT = iqpt_pkg::FRAC_SHIFT,
    localparam int PROD_W    = SAMPLE_W + CODE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       s1_valid,
    input  logic signed [SAMPLE_W-1:0] s1_i,
    input  logic signed [SAMPLE_W-1:0] s1_q,
    input  logic signed [PROD_W-1:0]   s1_prod,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q
);
    localparam int ACC_W = PROD_W + 1;
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(64'sd1 <<< (FRAC_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] Q_MAX    = ACC_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] Q_MIN    = ACC_W'(-(64'sd1 <<< (SAMPLE_W - 1)));

    logic signed [ACC_W-1:0]    acc_c;
    logic signed [ACC_W-1:0]    adj_c;
    logic signed [ACC_W-1:0]    sum_c;
    logic signed [SAMPLE_W-1:0] q_sat_c;

    // Round to nearest, halves toward +inf, then scale (R6)
    assign acc_c = ACC_W'(s1_prod) + HALF_LSB;
    assign adj_c = acc_c >>> FRAC_SHIFT;
    assign sum_c = ACC_W'(s1_q) + adj_c;

    // Clamp to the signed sample range (R7)
    always_comb begin
        if (sum_c > Q_MAX)      q_sat_c = Q_MAX[SAMPLE_W-1:0];
        else if (sum_c < Q_MIN) q_sat_c = Q_MIN[SAMPLE_W-1:0];
        else                    q_sat_c = sum_c[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_i <= s1_i;
                out_q <= q_sat_c;
            end
        end
    end

    // A zero product leaves Q untouched (R5)
    assert_zero_term_R5: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_prod == '0) |=> (out_q == $past(s1_q)));

    // A non-negative cross term can never drive Q downward (no wrap, R7)
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_prod[PROD_W-1]) |=> ($signed(out_q) >= $signed($past(s1_q))));

    // A negative cross term can never drive Q upward (no wrap, R7)
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_prod[PROD_W-1]) |=> ($signed(out_q) <= $signed($past(s1_q))));
endmodule

// File: rtl/iq_phase_trim.sv
module iq_phase_trim #(
    parameter int SAMPLE_W   = iqpt_pkg::SAMPLE_W,
    parameter int CODE_W     = iqpt_pkg::CODE_W,
    parameter int REG_W      = iqpt_pkg::REG_W,
    parameter int FRAC_SHIFT = iqpt_pkg::FRAC_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    input  logic [REG_W-1:0]    cfg_lo,
    input  logic [REG_W-1:0]    cfg_hi,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q
);
    localparam int PROD_W = SAMPLE_W + CODE_W;

    logic signed [CODE_W-1:0]   code;
    logic                       s1_valid;
    logic signed [SAMPLE_W-1:0] s1_i;
    logic signed [SAMPLE_W-1:0] s1_q;
    logic signed [PROD_W-1:0]   s1_prod;
    logic signed [SAMPLE_W-1:0] o_i;
    logic signed [SAMPLE_W-1:0] o_q;

    iqpt_code_join #(.REG_W(REG_W), .CODE_W(CODE_W)) u_join (
        .lo_byte (cfg_lo),
        .hi_byte (cfg_hi),
        .code    (code)
    );

    iqpt_mul_stage #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_i     ($signed(in_i)),
        .in_q     ($signed(in_q)),
        .code     (code),
        .s1_valid (s1_valid),
        .s1_i     (s1_i),
        .s1_q     (s1_q),
        .s1_prod  (s1_prod)
    );

    iqpt_sum_stage #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .FRAC_SHIFT(FRAC_SHIFT)) u_sum (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_i      (s1_i),
        .s1_q      (s1_q),
        .s1_prod   (s1_prod),
        .out_valid (out_valid),
        .out_i     (o_i),
        .out_q     (o_q)
    );

    assign out_i = o_i;
    assign out_q = o_q;

    // Valid follows the input two edges later once reset has been clear for two edges (R2)
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

    // I leaves exactly as it entered, aligned with its valid (R3)
    assert_i_align_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst, 2)) |-> (out_i == $past(in_i, 2)));

    // Reset clears the output register (R1)
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));
endmodule

// File: tb/test_iq_phase_trim.sv
`timescale 1ns/1ps
module test_iq_phase_trim;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [9:0] in_i = '0;
    logic [9:0] in_q = '0;
    logic [7:0] cfg_lo = '0;
    logic [7:0] cfg_hi = '0;
    logic       out_valid;
    logic [9:0] out_i;
    logic [9:0] out_q;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    iq_phase_trim i_iq_phase_trim (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Vectors {i, q, code}, each a 10-bit two's-complement field
    localparam int NV = 12;
    localparam logic [29:0] VEC [NV] = '{
        {10'h064, 10'h39C, 10'h000},  // 100, -100, 0
        {10'h100, 10'h000, 10'h004},  // 256, 0, 4   tie up
        {10'h100, 10'h000, 10'h3FC},  // 256, 0, -4  tie up to 0
        {10'h1FF, 10'h1FF, 10'h1FF},  // clamp high
        {10'h200, 10'h200, 10'h1FF},  // clamp low
        {10'h200, 10'h1FF, 10'h200},  // -512*-512 clamp high
        {10'h12C, 10'h2D4, 10'h064},  // 300, -300, 100
        {10'h2D4, 10'h3FF, 10'h39C},  // -300, -1, -100
        {10'h1FF, 10'h200, 10'h200},  // clamp low
        {10'h000, 10'h12C, 10'h1FF},  // I zero
        {10'h3FF, 10'h000, 10'h001},  // -1, 0, 1
        {10'h001, 10'h000, 10'h200}   // 1, 0, -512
    };

    function automatic int sx10(input logic [9:0] v);
        return int'($signed(v));
    endfunction

    // Expected Q from R6 and R7
    function automatic logic [9:0] model_q(input int i, input int q, input int code);
        int p;
        int adj;
        int s;
        p   = code * i;
        adj = (p + 1024) >>> 11;
        s   = q + adj;
        if (s > 511)  s = 511;
        if (s < -512) s = -512;
        return 10'(s);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic set_code(input logic [9:0] c, input logic [5:0] junk);
        cfg_lo = c[7:0];
        cfg_hi = {junk, c[9:8]};
    endtask

    logic [9:0] st_i [8];
    logic [9:0] st_q [8];
    logic [9:0] st_e [8];

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", 32'(out_valid), 0);
        check("R1 out_q in reset", 32'(out_q), 0);
        rst = 1'b0;

        // Table walk; odd entries load junk into the unused high bits (R4)
        for (int k = 0; k < NV; k++) begin
            logic [9:0] vi, vq, vc;
            {vi, vq, vc} = VEC[k];
            @(negedge clk);
            in_i = vi; in_q = vq; in_valid = 1'b1;
            set_code(vc, (k % 2 == 1) ? 6'b101101 : 6'b000000);
            @(negedge clk);
            in_valid = 1'b0;
            // R8: scribble the code after capture
            set_code(~vc, 6'b111111);
            check("R2 out_valid after one edge", 32'(out_valid), 0);
            @(negedge clk);
            check("R2 out_valid after two edges", 32'(out_valid), 1);
            check("R3 out_i", 32'(out_i), 32'(vi));
            check("R6/R7/R8 out_q", 32'(out_q), 32'(model_q(sx10(vi), sx10(vq), sx10(vc))));
            if (vc == 10'h000) check("R5 transparent", 32'(out_q), 32'(vq));
            if (k % 2 == 1) check("R4 high junk bits ignored", 32'(out_q),
                                  32'(model_q(sx10(vi), sx10(vq), sx10(vc))));
            @(negedge clk);
            // R9: hold with no new pair
            check("R9 out_q holds", 32'(out_q), 32'(model_q(sx10(vi), sx10(vq), sx10(vc))));
            check("R2 out_valid low when idle", 32'(out_valid), 0);
        end

        // R8: back-to-back stream with the code changing every cycle
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R2 stream valid", 32'(out_valid), 1);
                check("R3 stream out_i", 32'(out_i), 32'(st_i[k-2]));
                check("R8 stream out_q", 32'(out_q), 32'(st_e[k-2]));
            end
            if (k < 8) begin
                logic [9:0] c;
                c = 10'(k * 97 - 300);
                st_i[k] = 10'(k * 71 - 250);
                st_q[k] = 10'(k * 53 - 200);
                st_e[k] = model_q(sx10(st_i[k]), sx10(st_q[k]), sx10(c));
                in_i = st_i[k]; in_q = st_q[k]; set_code(c, 6'b010101);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end

        // R1: synchronous reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 0);
        check("R1 out_i after reset", 32'(out_i), 0);
        check("R1 out_q after reset", 32'(out_q), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule